// File: doc/BRIEF.md
# Vendor Request Serial Register Bridge

This block sits behind a control-transfer front end that has already split each vendor request into a setup strobe and a stream of payload bytes. It turns numbered write requests into updates of the configuration registers of a serial port. Those registers are a 32-bit baud divisor, the line control byte, the modem control byte and a flag that makes the transmitter wait for CTS. It answers read requests with the live modem status or the stored line control byte.

It also watches the serial core's modem status and line status bytes. When one of their change or error bits becomes set, it offers a two-byte report to an interrupt-style channel. The report holds the modem status first and the line status second. It stays offered until a valid/ready handshake takes it. The divisor is the 115200 reference rate divided by the wanted baud rate. The default of 12 gives 9600 baud.

Top module: `vreq_serial_bridge`

## Requirements
- R1: After reset, baud_div is 12, line_ctrl is 0x03, modem_ctrl is 0x00 and cts_required is 0. req_ack, req_stall, rdat_vld and rpt_vld are all 0.
- R2: A setup with type 0x40, code 5 and length 4 takes four payload bytes, which may have gaps between them. The first byte is the least significant. baud_div takes the assembled value and req_ack pulses for one cycle, both in the cycle after the fourth byte.
- R3: A setup with type 0x40 and length 1 writes its byte to line_ctrl (code 7) or to modem_ctrl (code 10). The register and a one-cycle req_ack both show in the cycle after the byte.
- R4: A setup with type 0xC0 and length 1 is a read. Code 2 returns modem_stat as sampled in the setup cycle; code 6 returns line_ctrl. rdat_vld, rdat and req_ack all show in the cycle after the setup.
- R5: A type 0x40, code 12, length 1 write sets cts_required to bit 0 of its byte. tx_enable is 1 when cts_required is 0 or when modem_stat bit 4 (CTS) is 1.
- R6: A type 0x40, code 11, length 1 write is acknowledged like any other write and changes no register.
- R7: A setup whose type is neither 0x40 nor 0xC0 gives neither ack nor stall and changes nothing. So does a setup whose code belongs only to the other direction: codes 2 and 6 with type 0x40, or codes 5, 7, 10, 11 and 12 with type 0xC0.
- R8: A setup with type 0x40 or 0xC0 gets a one-cycle req_stall in the next cycle, with no ack and no register change, in two cases. The first is a code outside {2, 5, 6, 7, 10, 11, 12}. The second is a code that matches the type but a length other than 4 for code 5 or other than 1 for the others.
- R9: Setup strobes that arrive while a write payload is still being collected are ignored. A wdat_vld outside a write payload is ignored.
- R10: An event is a 0-to-1 change, against the previous cycle, of any of modem_stat[3:0], line_stat[7] or line_stat[4:1]. All of them count as 0 before the first cycle after reset. An event seen while no report is pending makes rpt_vld 1 in the next cycle, with rpt_modem and rpt_line holding the event cycle's inputs. The report holds until a cycle with rpt_vld and rpt_rdy both 1, and rpt_vld is 0 in the cycle after that. Events seen while a report is pending, including in the handshake cycle, are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_vld | input | 1 | Setup strobe, one cycle per request |
| req_type | input | 8 | Request type: 0x40 for write, 0xC0 for read |
| req_code | input | 8 | Request code |
| req_len | input | 16 | Payload length in bytes |
| wdat_vld | input | 1 | Write payload byte valid |
| wdat | input | 8 | Write payload byte |
| req_ack | output | 1 | Request completed |
| req_stall | output | 1 | Request refused |
| rdat_vld | output | 1 | Read reply byte valid |
| rdat | output | 8 | Read reply byte |
| modem_stat | input | 8 | Modem status byte from the serial core; bit 4 is CTS |
| line_stat | input | 8 | Line status byte from the serial core |
| baud_div | output | 32 | Baud divisor register |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 8 | Modem control register |
| cts_required | output | 1 | Transmission waits for CTS |
| tx_enable | output | 1 | Transmitter allowed to send |
| rpt_vld | output | 1 | Status report pending |
| rpt_rdy | input | 1 | Report channel takes the report |
| rpt_modem | output | 8 | Report byte 0: modem status |
| rpt_line | output | 8 | Report byte 1: line status |

## Verification
The divisor write is sent with gaps between its payload bytes and with distinct byte values, so a swapped byte order or a miscounted payload shows up. Writes, reads, the no-op code and the CTS flag are mixed with three kinds of bad setup: wrong-direction setups, unknown codes and wrong lengths. This separates the silent-ignore path from the stall path. Setup strobes are also sent in the middle of a payload, and stray payload bytes are sent while idle. The status inputs are given rising edges when no report is pending, while one is pending, and in the handshake cycle itself, which shows whether a pending report is held or overwritten.

// File: rtl/vreq_serial_bridge.sv
module vreq_serial_bridge #(
  parameter logic [31:0] RESET_DIV = 32'd12,
  parameter logic [7:0]  RESET_LCR = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_vld,
  input  logic [7:0]  req_type,
  input  logic [7:0]  req_code,
  input  logic [15:0] req_len,
  input  logic        wdat_vld,
  input  logic [7:0]  wdat,
  output logic        req_ack,
  output logic        req_stall,
  output logic        rdat_vld,
  output logic [7:0]  rdat,
  input  logic [7:0]  modem_stat,
  input  logic [7:0]  line_stat,
  output logic [31:0] baud_div,
  output logic [7:0]  line_ctrl,
  output logic [7:0]  modem_ctrl,
  output logic        cts_required,
  output logic        tx_enable,
  output logic        rpt_vld,
  input  logic        rpt_rdy,
  output logic [7:0]  rpt_modem,
  output logic [7:0]  rpt_line
);
  localparam logic [7:0] TYPE_WR = 8'h40, TYPE_RD = 8'hC0;
  localparam logic [7:0] C_MSR = 8'd2, C_DIV = 8'd5, C_LCR_RD = 8'd6, C_LCR_WR = 8'd7;
  localparam logic [7:0] C_MCR = 8'd10, C_NOP = 8'd11, C_CTS = 8'd12;

  wire is_wr   = req_type == TYPE_WR;
  wire is_rd   = req_type == TYPE_RD;
  wire code_wr = req_code == C_DIV || req_code == C_LCR_WR || req_code == C_MCR ||
                 req_code == C_NOP || req_code == C_CTS;
  wire code_rd = req_code == C_MSR || req_code == C_LCR_RD;
  wire [15:0] exp_len = (req_code == C_DIV) ? 16'd4 : 16'd1;

  logic       busy;
  logic [7:0] code_q;
  logic [1:0] cnt, last;
  logic [23:0] shreg;
  logic [8:0] flags_q;

  wire take    = req_vld && !busy && (is_wr || is_rd);
  wire dir_ok  = (is_wr && code_wr) || (is_rd && code_rd);
  wire len_ok  = req_len == exp_len;
  wire bad     = take && (!(code_wr || code_rd) || (dir_ok && !len_ok));
  wire go_rd   = take && is_rd && code_rd && len_ok;
  wire go_wr   = take && is_wr && code_wr && len_ok;
  wire commit  = busy && wdat_vld && cnt == last;

  wire [8:0] flags = {line_stat[7], line_stat[4:1], modem_stat[3:0]};
  wire rise = |(flags & ~flags_q);

  assign tx_enable = !cts_required || modem_stat[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; code_q <= '0; cnt <= '0; last <= '0; shreg <= '0;
      req_ack <= 1'b0; req_stall <= 1'b0; rdat_vld <= 1'b0; rdat <= '0;
      baud_div <= RESET_DIV; line_ctrl <= RESET_LCR; modem_ctrl <= '0;
      cts_required <= 1'b0;
    end else begin
      req_ack   <= commit || go_rd;
      req_stall <= bad;
      rdat_vld  <= go_rd;
      if (go_rd) rdat <= (req_code == C_MSR) ? modem_stat : line_ctrl;
      if (go_wr) begin
        busy   <= 1'b1;
        code_q <= req_code;
        cnt    <= '0;
        last   <= 2'(exp_len - 16'd1);
      end else if (busy && wdat_vld) begin
        cnt   <= cnt + 2'd1;
        shreg <= {wdat, shreg[23:8]};
        if (commit) begin
          busy <= 1'b0;
          case (code_q)
            C_DIV:    baud_div     <= {wdat, shreg};
            C_LCR_WR: line_ctrl    <= wdat;
            C_MCR:    modem_ctrl   <= wdat;
            C_CTS:    cts_required <= wdat[0];
            default:  ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0; rpt_vld <= 1'b0; rpt_modem <= '0; rpt_line <= '0;
    end else begin
      flags_q <= flags;
      if (rpt_vld && rpt_rdy) rpt_vld <= 1'b0;
      else if (!rpt_vld && rise) begin
        rpt_vld   <= 1'b1;
        rpt_modem <= modem_stat;
        rpt_line  <= line_stat;
      end
    end
  end
endmodule

// File: rtl/vreq_serial_bridge_chk.sv
module vreq_serial_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_vld,
  input logic [7:0]  req_type,
  input logic        wdat_vld,
  input logic        req_ack,
  input logic        req_stall,
  input logic        rdat_vld,
  input logic [31:0] baud_div,
  input logic [7:0]  line_ctrl,
  input logic [7:0]  modem_ctrl,
  input logic        cts_required,
  input logic        rpt_vld,
  input logic        rpt_rdy,
  input logic [7:0]  rpt_modem,
  input logic [7:0]  rpt_line
);
  p_ack_stall_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ack && req_stall));

  p_read_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_vld |-> req_ack);

  p_stall_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |-> $stable(baud_div) && $stable(line_ctrl) && $stable(modem_ctrl) && $stable(cts_required));

  p_foreign_type_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_type != 8'h40 && req_type != 8'hC0 && !wdat_vld) |=> (!req_ack && !req_stall));

  p_report_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_vld && !rpt_rdy) |=> (rpt_vld && $stable(rpt_modem) && $stable(rpt_line)));

  p_report_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_vld && rpt_rdy) |=> !rpt_vld);
endmodule

bind vreq_serial_bridge vreq_serial_bridge_chk u_chk (.*);

// File: tb/test_vreq_serial_bridge.sv
`timescale 1ns/1ps
module test_vreq_serial_bridge;
  logic clk = 0, rst_n = 0;
  logic req_vld = 0; logic [7:0] req_type = 0, req_code = 0; logic [15:0] req_len = 0;
  logic wdat_vld = 0; logic [7:0] wdat = 0;
  logic [7:0] modem_stat = 0, line_stat = 0;
  logic rpt_rdy = 0;
  logic req_ack, req_stall, rdat_vld, cts_required, tx_enable, rpt_vld;
  logic [7:0] rdat, line_ctrl, modem_ctrl, rpt_modem, rpt_line;
  logic [31:0] baud_div;

  always #4 clk = ~clk;

  vreq_serial_bridge i_vreq_serial_bridge (.*);

  int checks = 0, fails = 0, acks = 0, stalls = 0;
  bit finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  bit m_busy, m_ack, m_stall, m_rdv, m_pend, m_cts;
  byte unsigned m_code, m_rdb, m_lcr, m_mcr, m_rm, m_rl;
  int unsigned m_baud;
  int m_need;
  byte unsigned q[$];
  logic [8:0] m_prev;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ack = 0; m_stall = 0; m_rdv = 0; m_pend = 0; m_cts = 0;
      m_lcr = 8'h03; m_mcr = 0; m_baud = 12; m_prev = 0; m_rdb = 0; q.delete();
    end else begin
      logic [8:0] f;
      bit old;
      int dir;
      m_ack = 0; m_stall = 0; m_rdv = 0;
      old = m_pend;
      if (old && rpt_rdy) m_pend = 0;
      f = {line_stat[7], line_stat[4:1], modem_stat[3:0]};
      if (!old && (f & ~m_prev) != 0) begin m_pend = 1; m_rm = modem_stat; m_rl = line_stat; end
      m_prev = f;
      if (m_busy) begin
        if (wdat_vld) begin
          q.push_back(wdat);
          if (q.size() == m_need) begin
            case (m_code)
              5:  m_baud = {q[3], q[2], q[1], q[0]};
              7:  m_lcr = q[0];
              10: m_mcr = q[0];
              12: m_cts = q[0][0];
              default: ;
            endcase
            m_ack = 1; m_busy = 0;
          end
        end
      end else if (req_vld && (req_type == 8'h40 || req_type == 8'hC0)) begin
        case (req_code)
          5, 7, 10, 11, 12: dir = 1;
          2, 6: dir = 2;
          default: dir = 0;
        endcase
        if (dir == 0) m_stall = 1;
        else if ((dir == 1) == (req_type == 8'h40)) begin
          m_need = (req_code == 5) ? 4 : 1;
          if (req_len != m_need) m_stall = 1;
          else if (dir == 2) begin
            m_rdv = 1; m_ack = 1; m_rdb = (req_code == 2) ? modem_stat : m_lcr;
          end else begin
            m_busy = 1; m_code = req_code; q.delete();
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R2 baud_div", baud_div, m_baud);
      chk("R3 line_ctrl", line_ctrl, m_lcr);
      chk("R3 modem_ctrl", modem_ctrl, m_mcr);
      chk("R5 cts_required", cts_required, m_cts);
      chk("R5 tx_enable", tx_enable, !m_cts || modem_stat[4]);
      chk("R6 req_ack", req_ack, m_ack);
      chk("R8 req_stall", req_stall, m_stall);
      chk("R4 rdat_vld", rdat_vld, m_rdv);
      if (m_rdv) chk("R4 rdat", rdat, m_rdb);
      chk("R10 rpt_vld", rpt_vld, m_pend);
      if (m_pend) begin
        chk("R10 rpt_modem", rpt_modem, m_rm);
        chk("R10 rpt_line", rpt_line, m_rl);
      end
      if (req_ack) acks++;
      if (req_stall) stalls++;
    end
  end

  task automatic setup(logic [7:0] t, logic [7:0] c, logic [15:0] l);
    @(negedge clk); req_vld = 1; req_type = t; req_code = c; req_len = l;
    @(negedge clk); req_vld = 0;
  endtask
  task automatic send(logic [7:0] b);
    @(negedge clk); wdat_vld = 1; wdat = b;
    @(negedge clk); wdat_vld = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int a0, s0;
    idle(3); rst_n = 1;
    @(posedge clk); #2;
    // R1 reset state
    chk("R1 baud_div", baud_div, 12);
    chk("R1 line_ctrl", line_ctrl, 8'h03);
    chk("R1 modem_ctrl", modem_ctrl, 0);
    chk("R1 cts_required", cts_required, 0);
    chk("R1 outputs idle", {req_ack, req_stall, rdat_vld, rpt_vld}, 0);

    // R2 divisor, bytes with gaps
    setup(8'h40, 5, 4);
    send(8'h11); idle(2); send(8'h22); send(8'h33); idle(1); send(8'h44);
    idle(1);
    chk("R2 divisor assembled", baud_div, 32'h44332211);

    // R3
    setup(8'h40, 7, 1); send(8'h1B);
    setup(8'h40, 10, 1); send(8'h0B);
    idle(1);
    chk("R3 line_ctrl written", line_ctrl, 8'h1B);
    chk("R3 modem_ctrl written", modem_ctrl, 8'h0B);

    // R4 reads
    modem_stat = 8'hA0;
    setup(8'hC0, 2, 1);
    setup(8'hC0, 6, 1);

    // R5 CTS gating
    setup(8'h40, 12, 1); send(8'h01);
    idle(2); modem_stat = 8'hB0; idle(2); modem_stat = 8'hA0;
    idle(1); chk("R5 tx held without CTS", tx_enable, 0);
    setup(8'h40, 12, 1); send(8'h00);

    // R6 no-op write
    a0 = acks;
    setup(8'h40, 11, 1); send(8'hFF);
    idle(1);
    chk("R6 no-op acked", acks - a0, 1);
    chk("R6 regs unchanged", {line_ctrl, modem_ctrl}, 16'h1B0B);

    // R7 ignored requests
    a0 = acks; s0 = stalls;
    setup(8'h21, 7, 1); setup(8'h40, 2, 1); setup(8'h40, 6, 1); setup(8'hC0, 7, 1);
    idle(2);
    chk("R7 no ack no stall", {acks - a0, stalls - s0}, 0);

    // R8 stalls
    s0 = stalls;
    setup(8'h40, 3, 1); setup(8'hC0, 9, 1); setup(8'h40, 5, 1); setup(8'h40, 7, 2); setup(8'hC0, 2, 0);
    idle(2);
    chk("R8 five stalls", stalls - s0, 5);
    chk("R8 line_ctrl kept", line_ctrl, 8'h1B);

    // R9 setup during payload, stray bytes
    send(8'h55); idle(1);
    setup(8'h40, 5, 4);
    send(8'h01); setup(8'h40, 7, 1); setup(8'h41, 3, 9); send(8'h02); send(8'h03);
    setup(8'hC0, 2, 1); send(8'h04);
    idle(2);
    chk("R9 divisor after interleave", baud_div, 32'h04030201);
    chk("R9 line_ctrl untouched", line_ctrl, 8'h1B);

    // R10 reports
    rpt_rdy = 0;
    modem_stat = 8'hA1; idle(3);
    modem_stat = 8'hA3; idle(3);
    chk("R10 pending report kept", {rpt_vld, rpt_modem}, {1'b1, 8'hA1});
    rpt_rdy = 1; line_stat = 8'h08; idle(1); rpt_rdy = 0; idle(2);
    chk("R10 handshake-cycle event dropped", rpt_vld, 0);
    line_stat = 8'h88; idle(3);
    chk("R10 new report", {rpt_vld, rpt_line}, {1'b1, 8'h88});
    rpt_rdy = 1; idle(2); rpt_rdy = 0;
    modem_stat = 8'h00; line_stat = 8'h00; idle(2);
    modem_stat = 8'h04; line_stat = 8'h02; idle(2);
    rpt_rdy = 1; idle(2);
    summary();
  end
endmodule